// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block chooses the operating mode of a small microcontroller core and drives the clock enables that go with it. While the core runs, the system clock comes from the fast oscillator, divided by a power of two from 1 to 64. When the fast-clock select is cleared, the system clock comes from the slow oscillator instead and the fast oscillator is switched off.

A halt request from the CPU puts the block into one of four low-power states. The choice depends on the idle-enable bit, the keep-oscillator-in-idle bit, the low-voltage-detector enable and the watchdog enable. Each of these states keeps its own set of clocks running. A wake-up event returns the block to the running mode that was active before the halt.

Both oscillators are modelled in the core clock domain. `clk` is the fast oscillator. `lo_tick` is a one-cycle strobe for each period of the slow oscillator. The divided system clock is presented as `sys_tick`, a one-cycle enable strobe that marks each system-clock edge. All pins are plain control and status levels, so there is no streaming handshake and no back-pressure.

Top module: `power_clock_ctrl`

## Requirements
- R1: While `rst_n` is low the outputs are:
  - `mode_o` = 0
  - `cpu_clk_en` = 0
  - `hosc_en` = 1
  - `sub_clk_en` = 1
  - the divide ratio is 1
- R2: In mode 0, `sys_tick` pulses once every 2^`div_sel` cycles for codes 0 to 6. Code 7 gives a ratio of 1, which is a pulse every cycle. `hosc_en` is 1 in this mode.
- R3: A new `div_sel` value is taken only at the clock edge that ends a divided period. The period in progress always completes with the old ratio.
- R4: When `hs_sel` is 0 while running, the block is in mode 1:
  - `hosc_en` is 0
  - `sys_tick` equals `lo_tick`
  - the fast divider holds its count
- R5: A halt with `idle_en`=0, `lvd_en`=0 and `wdt_en`=0 enters mode 2. In mode 2, `cpu_clk_en`, `hosc_en`, `sub_clk_en` and `sys_tick` are all 0.
- R6: A halt with `idle_en`=0 and either `lvd_en` or `wdt_en` set enters mode 3.
  - If `lvd_en` or `wdt_en` becomes 1 while in mode 2, the block moves to mode 3 on the next edge.
  - In mode 3, `sub_clk_en` equals `lvd_en | wdt_en`.
- R7: A halt with `idle_en`=1 and `osc_keep_idle`=0 enters mode 4. In mode 4, `hosc_en`=0, `sys_tick`=0, `sub_clk_en`=1 and `cpu_clk_en`=0.
- R8: A halt with `idle_en`=1 and `osc_keep_idle`=1 enters mode 5. In mode 5:
  - the system clock of the saved running mode keeps ticking
  - `cpu_clk_en`=0
  - `sub_clk_en`=1
- R9: `wake_evt` in any of modes 2 to 5 returns the block to the saved running mode (0 or 1) on the next edge. `cpu_clk_en` then rises on the edge that ends the first `sys_tick` cycle of the running mode.
- R10: Two inputs are ignored in the wrong state:
  - `halt_req` has no effect in modes 2 to 5.
  - `wake_evt` has no effect in modes 0 and 1.
- R11: `mode_o` is registered and shows the state code one cycle after the state changes. The codes are:
  - 0 normal
  - 1 slow
  - 2 deep sleep
  - 3 sleep with sub-clock
  - 4 idle with oscillator stopped
  - 5 idle with oscillator running
- R12: The edge that samples an accepted halt clears `cpu_clk_en`. After reset, `cpu_clk_en` rises on the edge that ends the first `sys_tick` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | CPU halt request, one cycle |
| wake_evt | input | 1 | Wake-up event |
| idle_en | input | 1 | Halt goes to an idle state rather than a sleep state |
| osc_keep_idle | input | 1 | Keep the system oscillator running in idle |
| hs_sel | input | 1 | 1 selects the fast clock, 0 the slow clock |
| div_sel | input | DIV_SEL_W | Divide-ratio code |
| lvd_en | input | 1 | Voltage detector enabled |
| wdt_en | input | 1 | Watchdog enabled |
| lo_tick | input | 1 | Slow-oscillator period strobe |
| cpu_clk_en | output | 1 | CPU clock enable |
| hosc_en | output | 1 | Fast oscillator enable |
| sub_clk_en | output | 1 | Low-speed sub-clock enable |
| sys_tick | output | 1 | Divided system-clock strobe |
| mode_o | output | 3 | Registered mode code |

## Verification
The assertions check on every cycle that:
- the divide counter never passes the end of its period
- the ratio changes only at a period boundary
- the CPU enable is low in every low-power state
- deep sleep is held only while the voltage detector is off
- no system tick appears while the oscillator is stopped
- a halt does not move a low-power state

The bench's scenarios show the rest:
- the mapping from each configuration to its mode code
- the return to the right running mode on wake
- the exact length of the period that straddles a ratio change
- the slow-clock ticks that continue through an idle with the oscillator running

A behavioural model compares every output on every cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_RUN_FAST     = 3'd0,
    PM_RUN_SLOW     = 3'd1,
    PM_SLEEP_DEEP   = 3'd2,
    PM_SLEEP_SUB    = 3'd3,
    PM_IDLE_OSC_OFF = 3'd4,
    PM_IDLE_OSC_ON  = 3'd5
  } pm_state_e;

  function automatic logic pm_is_running(pm_state_e s);
    return (s == PM_RUN_FAST) || (s == PM_RUN_SLOW);
  endfunction

  function automatic pm_state_e pm_pick_low(logic idle_en, logic keep,
                                            logic lvd_en, logic wdt_en);
    if (idle_en) return keep ? PM_IDLE_OSC_ON : PM_IDLE_OSC_OFF;
    return (lvd_en || wdt_en) ? PM_SLEEP_SUB : PM_SLEEP_DEEP;
  endfunction

endpackage

// File: rtl/pmc_divider.sv
module pmc_divider #(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_run,
  input  logic             lo_run,
  input  logic             lo_tick,
  input  logic [SEL_W-1:0] div_sel,
  output logic             sys_tick,
  output logic             wrap_o
);
  localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
  localparam int SH_W  = (MAX_SHIFT > 0) ? $clog2(MAX_SHIFT + 1) : 1;

  logic [SH_W-1:0]  sh_q, sh_next;
  logic [CNT_W-1:0] cnt_q, last;
  logic [CNT_W:0]   span;
  logic             wrap;

  // Codes above the largest shift fold to a ratio of 1.
  always_comb begin
    if (div_sel > SEL_W'(MAX_SHIFT)) sh_next = '0;
    else                             sh_next = SH_W'(div_sel);
  end

  assign span   = {{CNT_W{1'b0}}, 1'b1} << sh_q;
  assign last   = CNT_W'(span - (CNT_W+1)'(1));
  assign wrap   = hs_run && (cnt_q == last);
  assign wrap_o = wrap;

  // The ratio is latched only when a period ends, so no short pulse appears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (hs_run) begin
      if (wrap) begin
        cnt_q <= '0;
        sh_q  <= sh_next;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sys_tick = wrap || (lo_run && lo_tick);

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  a_r3_ratio_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_q) |-> $past(wrap));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      wake_evt,
  input  logic      idle_en,
  input  logic      osc_keep_idle,
  input  logic      hs_sel,
  input  logic      lvd_en,
  input  logic      wdt_en,
  input  logic      sys_tick,
  output pm_state_e state_o,
  output pm_state_e saved_o,
  output logic      cpu_en_o
);
  pm_state_e state_q, state_d, saved_q, saved_d;
  logic      cpu_q, cpu_d;

  always_comb begin
    state_d = state_q;
    saved_d = saved_q;
    cpu_d   = cpu_q;
    if (pm_is_running(state_q)) begin
      if (halt_req) begin
        saved_d = state_q;
        state_d = pm_pick_low(idle_en, osc_keep_idle, lvd_en, wdt_en);
        cpu_d   = 1'b0;
      end else begin
        state_d = hs_sel ? PM_RUN_FAST : PM_RUN_SLOW;
        if (sys_tick) cpu_d = 1'b1;
      end
    end else if (wake_evt) begin
      state_d = saved_q;
    end else if (state_q == PM_SLEEP_DEEP && (lvd_en || wdt_en)) begin
      // The deepest state may not persist once a sub-clock user is enabled.
      state_d = PM_SLEEP_SUB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN_FAST;
      saved_q <= PM_RUN_FAST;
      cpu_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      saved_q <= saved_d;
      cpu_q   <= cpu_d;
    end
  end

  assign state_o  = state_q;
  assign saved_o  = saved_q;
  assign cpu_en_o = cpu_q;

  a_r5_cpu_off_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_is_running(state_q) |-> !cpu_q);

  a_r5_deep_needs_lvd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SLEEP_DEEP) |-> $past(!lvd_en));

  a_r9_cpu_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_q) |-> $past(sys_tick));

  a_r10_halt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_is_running(state_q) && state_q != PM_SLEEP_DEEP && !wake_evt)
      |=> $stable(state_q));

endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pm_state_e  state,
  input  pm_state_e  saved,
  input  logic       lvd_en,
  input  logic       wdt_en,
  output logic       hs_run,
  output logic       lo_run,
  output logic       sub_en,
  output logic [2:0] mode_o
);
  logic       idle_run;
  logic [2:0] mode_q;

  assign idle_run = (state == PM_IDLE_OSC_ON);
  assign hs_run   = (state == PM_RUN_FAST) || (idle_run && saved == PM_RUN_FAST);
  assign lo_run   = (state == PM_RUN_SLOW) || (idle_run && saved == PM_RUN_SLOW);

  always_comb begin
    unique case (state)
      PM_SLEEP_DEEP: sub_en = 1'b0;
      PM_SLEEP_SUB:  sub_en = lvd_en || wdt_en;
      default:       sub_en = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 3'd0;
    else        mode_q <= state;
  end

  assign mode_o = mode_q;

  a_r11_mode_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= 3'd5);

endmodule

// File: rtl/power_clock_ctrl.sv
module power_clock_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_SEL_W = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_req,
  input  logic                 wake_evt,
  input  logic                 idle_en,
  input  logic                 osc_keep_idle,
  input  logic                 hs_sel,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 lvd_en,
  input  logic                 wdt_en,
  input  logic                 lo_tick,
  output logic                 cpu_clk_en,
  output logic                 hosc_en,
  output logic                 sub_clk_en,
  output logic                 sys_tick,
  output logic [2:0]           mode_o
);
  pm_state_e state, saved;
  logic      hs_run, lo_run, wrap, tick;

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_evt(wake_evt),
    .idle_en(idle_en), .osc_keep_idle(osc_keep_idle), .hs_sel(hs_sel),
    .lvd_en(lvd_en), .wdt_en(wdt_en), .sys_tick(tick),
    .state_o(state), .saved_o(saved), .cpu_en_o(cpu_clk_en)
  );

  pmc_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .saved(saved),
    .lvd_en(lvd_en), .wdt_en(wdt_en), .hs_run(hs_run), .lo_run(lo_run),
    .sub_en(sub_clk_en), .mode_o(mode_o)
  );

  pmc_divider #(.SEL_W(DIV_SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_n), .hs_run(hs_run), .lo_run(lo_run),
    .lo_tick(lo_tick), .div_sel(div_sel), .sys_tick(tick), .wrap_o(wrap)
  );

  assign hosc_en  = hs_run;
  assign sys_tick = tick;

  a_r7_no_tick_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SLEEP_DEEP || state == PM_SLEEP_SUB || state == PM_IDLE_OSC_OFF)
      |-> !tick);

  a_r4_slow_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_RUN_SLOW) |-> !wrap);

endmodule

// File: tb/power_clock_ctrl_test.sv
module power_clock_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n, halt_req, wake_evt, idle_en, osc_keep_idle, hs_sel;
  logic [2:0] div_sel;
  logic       lvd_en, wdt_en, lo_tick;
  logic       cpu_clk_en, hosc_en, sub_clk_en, sys_tick;
  logic [2:0] mode_o;

  int checks = 0, failures = 0, cyc = 0;

  // Reference model state.
  int ms = 0, msv = 0, mcpu = 0, mcnt = 0, msh = 0, mmode = 0;

  always #4 clk = ~clk;

  power_clock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_evt(wake_evt),
    .idle_en(idle_en), .osc_keep_idle(osc_keep_idle), .hs_sel(hs_sel),
    .div_sel(div_sel), .lvd_en(lvd_en), .wdt_en(wdt_en), .lo_tick(lo_tick),
    .cpu_clk_en(cpu_clk_en), .hosc_en(hosc_en), .sub_clk_en(sub_clk_en),
    .sys_tick(sys_tick), .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_hrun();
    return (ms == 0 || (ms == 5 && msv == 0)) ? 1 : 0;
  endfunction
  function automatic int m_lrun();
    return (ms == 1 || (ms == 5 && msv == 1)) ? 1 : 0;
  endfunction
  function automatic int m_wrap();
    return (m_hrun() == 1 && mcnt == (1 << msh) - 1) ? 1 : 0;
  endfunction
  function automatic int m_tick();
    return (m_wrap() == 1 || (m_lrun() == 1 && lo_tick)) ? 1 : 0;
  endfunction
  function automatic int m_sub();
    if (ms == 2) return 0;
    if (ms == 3) return (lvd_en || wdt_en) ? 1 : 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = 0; msv = 0; mcpu = 0; mcnt = 0; msh = 0; mmode = 0;
    end else begin
      int t, w, h;
      t = m_tick(); w = m_wrap(); h = m_hrun();
      mmode = ms;
      if (h == 1) begin
        if (w == 1) begin
          mcnt = 0;
          msh = (div_sel > 6) ? 0 : int'(div_sel);
        end else mcnt++;
      end
      if (ms <= 1) begin
        if (halt_req) begin
          msv = ms; mcpu = 0;
          if (idle_en) ms = osc_keep_idle ? 5 : 4;
          else ms = (lvd_en || wdt_en) ? 3 : 2;
        end else begin
          ms = hs_sel ? 0 : 1;
          if (t == 1) mcpu = 1;
        end
      end else if (wake_evt) ms = msv;
      else if (ms == 2 && (lvd_en || wdt_en)) ms = 3;
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cpu_clk_en == mcpu[0], "R9 cpu_clk_en model", int'(cpu_clk_en), mcpu);
      chk(hosc_en == m_hrun()[0], "R4 hosc_en model", int'(hosc_en), m_hrun());
      chk(sub_clk_en == m_sub()[0], "R6 sub_clk_en model", int'(sub_clk_en), m_sub());
      chk(sys_tick == m_tick()[0], "R2 sys_tick model", int'(sys_tick), m_tick());
      chk(int'(mode_o) == mmode, "R11 mode_o model", int'(mode_o), mmode);
    end
  end

  initial begin
    lo_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      lo_tick = (cyc % 5 == 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_halt();
    halt_req = 1'b1; step(1); halt_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (sys_tick) c++;
    end
    #5;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    report();
  end

  initial begin
    int c;
    rst_n = 1'b0; halt_req = 0; wake_evt = 0; idle_en = 0; osc_keep_idle = 0;
    hs_sel = 1; div_sel = 3'd7; lvd_en = 0; wdt_en = 0;
    step(3);
    @(negedge clk);
    chk(mode_o == 3'd0, "R1 reset mode", int'(mode_o), 0);
    chk(cpu_clk_en == 1'b0, "R1 reset cpu_clk_en", int'(cpu_clk_en), 0);
    chk(hosc_en == 1'b1, "R1 reset hosc_en", int'(hosc_en), 1);
    chk(sub_clk_en == 1'b1, "R1 reset sub_clk_en", int'(sub_clk_en), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    step(1);
    @(negedge clk);
    chk(cpu_clk_en == 1'b1, "R12 cpu enable after first tick", int'(cpu_clk_en), 1);

    // R2: ratio 4, then code 7 gives ratio 1.
    div_sel = 3'd2; step(3);
    count_ticks(40, c);
    chk(c == 10, "R2 ratio 4 tick count", c, 10);
    div_sel = 3'd7; step(5);
    count_ticks(16, c);
    chk(c == 16, "R2 code 7 ratio 1", c, 16);

    // R3: the 64-period in progress completes after a change to code 0.
    div_sel = 3'd6; step(70);
    @(negedge clk);
    while (!sys_tick) @(negedge clk);
    @(posedge clk); #1 div_sel = 3'd0;
    c = 0;
    do begin
      @(negedge clk); c++;
    end while (!sys_tick && c < 200);
    chk(c == 64, "R3 old period completes", c, 64);
    @(negedge clk);
    chk(sys_tick == 1'b1, "R3 new ratio after boundary", int'(sys_tick), 1);
    #5;

    // R4: slow mode.
    hs_sel = 1'b0; step(2);
    @(negedge clk);
    chk(hosc_en == 1'b0, "R4 slow hosc off", int'(hosc_en), 0);
    chk(mode_o == 3'd1, "R11 slow mode code", int'(mode_o), 1);
    #5;

    // R8: idle with oscillator running from slow mode.
    idle_en = 1'b1; osc_keep_idle = 1'b1; pulse_halt();
    @(negedge clk);
    chk(cpu_clk_en == 1'b0, "R12 halt clears cpu", int'(cpu_clk_en), 0);
    #5; step(1);
    @(negedge clk);
    chk(mode_o == 3'd5, "R8 idle running mode", int'(mode_o), 5);
    #5;
    count_ticks(10, c);
    chk(c == 2, "R8 slow ticks continue in idle", c, 2);

    // R9: wake returns to slow.
    pulse_wake(); step(1);
    @(negedge clk);
    chk(mode_o == 3'd1, "R9 wake to slow", int'(mode_o), 1);
    #5; step(8);
    @(negedge clk);
    chk(cpu_clk_en == 1'b1, "R9 cpu back on", int'(cpu_clk_en), 1);
    #5;

    // R7 and R10: idle with oscillator stopped from normal.
    hs_sel = 1'b1; div_sel = 3'd1; step(3);
    osc_keep_idle = 1'b0; pulse_halt(); step(1);
    @(negedge clk);
    chk(mode_o == 3'd4, "R7 idle stopped mode", int'(mode_o), 4);
    chk(hosc_en == 1'b0, "R7 hosc off", int'(hosc_en), 0);
    #5;
    count_ticks(10, c);
    chk(c == 0, "R7 no ticks", c, 0);
    pulse_halt(); step(2);
    @(negedge clk);
    chk(mode_o == 3'd4, "R10 halt ignored in idle", int'(mode_o), 4);
    #5;
    pulse_wake(); step(1);
    @(negedge clk);
    chk(mode_o == 3'd0, "R9 wake to normal", int'(mode_o), 0);
    #5; step(4);

    // R5 and R6: sleep states.
    idle_en = 1'b0; pulse_halt(); step(1);
    @(negedge clk);
    chk(mode_o == 3'd2, "R5 deep sleep mode", int'(mode_o), 2);
    chk(sub_clk_en == 1'b0, "R5 sub off", int'(sub_clk_en), 0);
    #5;
    wdt_en = 1'b1; step(2);
    @(negedge clk);
    chk(mode_o == 3'd3, "R6 promote on watchdog", int'(mode_o), 3);
    chk(sub_clk_en == 1'b1, "R6 sub on", int'(sub_clk_en), 1);
    #5;
    wdt_en = 1'b0; step(1);
    @(negedge clk);
    chk(sub_clk_en == 1'b0, "R6 sub follows enables", int'(sub_clk_en), 0);
    #5;
    pulse_wake(); step(4);
    lvd_en = 1'b1; pulse_halt(); step(1);
    @(negedge clk);
    chk(mode_o == 3'd3, "R6 lvd forces sub sleep", int'(mode_o), 3);
    #5;
    pulse_wake(); step(4);
    pulse_wake(); step(2);
    @(negedge clk);
    chk(mode_o == 3'd0, "R10 wake ignored when running", int'(mode_o), 0);
    #5; step(5);
    report();
  end
endmodule